// File: doc/BRIEF.md
# Write-Access Probe Register Window

This block is a small memory-mapped slave, no larger than 4 KiB, that host software uses to confirm that byte, halfword and word writes arrive at a device intact. Software picks one of a fixed set of numbered write tests by storing its number into a selector byte. The block then reports the access width that test needs, the byte offset inside the window it targets and the value to write. It watches every write to the window and counts each one that exactly fits the selected test.

Tests are numbered without gaps from zero. A discovery routine selects 0, 1, 2 and so on, reading the width code each time, and stops at the first number whose width code is not 1, 2 or 4. A zero-terminated ASCII identifier follows the header. The bus is a plain register interface: a byte address, 32-bit write data, four byte enables, one-cycle read and write strobes and a registered read-data return. All fields are little endian, so byte lane 0 carries the lowest-addressed byte.

Built-in tests: test 0 is a byte write of 0x5A at offset 0x101. Test 1 is a halfword write of 0xC3A5 at offset 0x202. Test 2 is a word write of 0x12345678 at offset 0x300. Test 3 is a word write of 0xDEADBEEF at offset 0xFFC.

Top module: `bus_probe_regs`

## Requirements
- R1: After reset no test is active: the width code (byte 1) reads 0 and the hit count (bytes 12-15) reads 0.
- R2: A write to word 0 with byte enable 0 set stores bus_wdata[7:0] as the test number. Byte 1 then reads 1, 2 or 4 for tests 0 to 3 and 0 for any other number. Byte 0 and the padding bytes 2 and 3 always read 0.
- R3: Word 1 (offset 4) reads the selected test's target offset and word 2 (offset 8) reads its expected value. Both read 0 when the number is unsupported.
- R4: A write counts as a hit when all three of these hold: bus_addr equals the target offset with its two low bits cleared, the byte enables equal exactly the width's lanes shifted to lane offset[1:0], and the enabled lanes carry the expected value shifted to that lane. Each hit adds one to the count in word 3.
- R5: A write with the wrong address, wrong byte enables or wrong data on an enabled lane does not count. Data on disabled lanes does not affect a match.
- R6: Every write of a test number, including the number already selected, clears the count to 0.
- R7: The count is CNT_W bits wide and stops at all-ones instead of wrapping.
- R8: Writes to the offset, data, count and name words are ignored. A word-0 write without byte enable 0 does not change the selection.
- R9: Bytes 16 to 23 read the ASCII identifier "BUSPROBE", byte 24 reads 0, and all other unused locations read 0.
- R10: Read data appears on bus_rdata on the clock edge that samples bus_rd and holds until the next read.
- R11: While an unsupported test number is selected, no write counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address inside the window |
| bus_wdata | input | 32 | Write data, lane 0 in bits 7:0 |
| bus_be | input | 4 | Byte enables for the write |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 32 | Registered read data |

## Verification
The state that is hardest to reach is the saturated counter, because the default width would need billions of hits. The bench therefore builds the block with a 3-bit count, drives more hits than that count can hold for every test, and then confirms the value stays at 7. It also checks that reselecting the same test clears the count. Near-miss writes are generated from each test's own description: the word address moved by one, one byte enable flipped, and one enabled data bit flipped. Garbage is also placed on the disabled lanes.

// File: rtl/bprobe_pkg.sv
package bprobe_pkg;
  localparam int NUM_TESTS  = 4;
  localparam int NAME_BYTES = 8;

  typedef struct packed {
    logic [7:0]  width;
    logic [31:0] offset;
    logic [31:0] data;
  } test_desc_t;

  function automatic test_desc_t test_lookup(input logic [7:0] sel);
    test_desc_t d;
    d = '0;
    case (sel)
      8'd0: d = '{width: 8'd1, offset: 32'h0000_0101, data: 32'h0000_005A};
      8'd1: d = '{width: 8'd2, offset: 32'h0000_0202, data: 32'h0000_C3A5};
      8'd2: d = '{width: 8'd4, offset: 32'h0000_0300, data: 32'h1234_5678};
      8'd3: d = '{width: 8'd4, offset: 32'h0000_0FFC, data: 32'hDEAD_BEEF};
      default: d = '0;
    endcase
    return d;
  endfunction

  function automatic logic [7:0] name_char(input int unsigned idx);
    logic [7:0] c;
    case (idx)
      0: c = "B";
      1: c = "U";
      2: c = "S";
      3: c = "P";
      4: c = "R";
      5: c = "O";
      6: c = "B";
      7: c = "E";
      default: c = 8'h00;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/bt_test_table.sv
module bt_test_table
  import bprobe_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  sel,
  output test_desc_t  desc,
  output logic        valid
);
  always_comb begin
    desc  = test_lookup(sel);
    valid = (desc.width == 8'd1) || (desc.width == 8'd2) || (desc.width == 8'd4);
  end

  AST_UNSUPPORTED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sel >= 8'(NUM_TESTS)) |-> (desc.width == 8'd0 && !valid)); // R2
endmodule

// File: rtl/bt_hit_detect.sv
module bt_hit_detect
  import bprobe_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              active,
  input  test_desc_t        desc,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [3:0]        be,
  output logic [CNT_W-1:0]  count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [3:0]  lane_mask;
  logic [31:0] bit_mask;
  logic [31:0] exp_shift;
  logic [31:0] word_addr;
  logic        hit;

  always_comb begin
    case (desc.width)
      8'd1:    lane_mask = 4'b0001 << desc.offset[1:0];
      8'd2:    lane_mask = 4'b0011 << desc.offset[1:0];
      default: lane_mask = 4'b1111;
    endcase
    for (int b = 0; b < 4; b++) bit_mask[8*b +: 8] = {8{lane_mask[b]}};
    exp_shift = desc.data << (8 * desc.offset[1:0]);
    word_addr = {desc.offset[31:2], 2'b00};
    hit = active && wr_en && (32'(addr) == word_addr) && (be == lane_mask)
          && (((wdata ^ exp_shift) & bit_mask) == 32'h0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr)               count <= '0;
    else if (hit && count != CNT_MAX) count <= count + 1'b1;
  end

  AST_CLEAR_ON_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0)); // R6
  AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_MAX && !clr) |=> (count == CNT_MAX)); // R7
  AST_HIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !clr && count != CNT_MAX) |=> (count == $past(count) + 1'b1)); // R4
  AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !clr) |=> $stable(count)); // R5
  AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !clr) |=> $stable(count)); // R11
endmodule

// File: rtl/bt_read_mux.sv
module bt_read_mux
  import bprobe_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  test_desc_t        desc,
  input  logic [CNT_W-1:0]  count,
  output logic [31:0]       rdata
);
  localparam int NAME_WORDS = (NAME_BYTES + 4) / 4;
  localparam int NAME_BASE  = 4;

  logic [31:0] name_words [NAME_WORDS];
  logic [31:0] rd_next;
  logic [ADDR_W-3:0] widx;

  for (genvar w = 0; w < NAME_WORDS; w++) begin : g_name
    for (genvar b = 0; b < 4; b++) begin : g_byte
      assign name_words[w][8*b +: 8] = name_char(4*w + b);
    end
  end

  always_comb begin
    widx    = addr[ADDR_W-1:2];
    rd_next = 32'h0;
    case (widx)
      '0:                        rd_next = {16'h0, desc.width, 8'h00};
      (ADDR_W-2)'(1):            rd_next = desc.offset;
      (ADDR_W-2)'(2):            rd_next = desc.data;
      (ADDR_W-2)'(3):            rd_next = 32'(count);
      default: begin
        for (int w = 0; w < NAME_WORDS; w++)
          if (widx == (ADDR_W-2)'(NAME_BASE + w)) rd_next = name_words[w];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R10
endmodule

// File: rtl/bus_probe_regs.sv
module bus_probe_regs
  import bprobe_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [3:0]        bus_be,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata
);
  localparam logic [7:0] SEL_IDLE = 8'hFF;

  logic [7:0]  sel_q;
  logic        sel_wr;
  test_desc_t  desc;
  logic        desc_ok;
  logic [CNT_W-1:0] count;

  assign sel_wr = bus_wr && bus_be[0] && (bus_addr[ADDR_W-1:2] == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)      sel_q <= SEL_IDLE;
    else if (sel_wr) sel_q <= bus_wdata[7:0];
  end

  bt_test_table u_table (
    .clk(clk), .rst_n(rst_n), .sel(sel_q), .desc(desc), .valid(desc_ok)
  );

  bt_hit_detect #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_hit (
    .clk(clk), .rst_n(rst_n), .clr(sel_wr), .active(desc_ok), .desc(desc),
    .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata), .be(bus_be), .count(count)
  );

  bt_read_mux #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(bus_rd), .addr(bus_addr), .desc(desc),
    .count(count), .rdata(bus_rdata)
  );

  AST_SEL_ONLY_BY_BYTE0: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_wr |=> $stable(sel_q)); // R8
  AST_SEL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |=> (sel_q == $past(bus_wdata[7:0]))); // R2
endmodule

// File: tb/bus_probe_regs_test.sv
module bus_probe_regs_test;
  localparam int ADDR_W = 12;
  localparam int CNT_W  = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [3:0]        bus_be = '0;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [31:0]       bus_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bus_probe_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_be(bus_be), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
  );

  function automatic logic [7:0] e_width(input int t);
    case (t) 0: return 8'd1; 1: return 8'd2; 2, 3: return 8'd4; default: return 8'd0; endcase
  endfunction
  function automatic logic [31:0] e_off(input int t);
    case (t) 0: return 32'h101; 1: return 32'h202; 2: return 32'h300; 3: return 32'hFFC;
      default: return 32'h0; endcase
  endfunction
  function automatic logic [31:0] e_data(input int t);
    case (t) 0: return 32'h5A; 1: return 32'hC3A5; 2: return 32'h12345678; 3: return 32'hDEADBEEF;
      default: return 32'h0; endcase
  endfunction
  function automatic logic [3:0] e_be(input int t);
    logic [3:0] m;
    m = (e_width(t) == 8'd1) ? 4'b0001 : (e_width(t) == 8'd2) ? 4'b0011 : 4'b1111;
    return m << e_off(t)[1:0];
  endfunction
  function automatic logic [31:0] e_bits(input int t);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = {8{e_be(t)[b]}};
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic sel(input int t);
    wr('0, 32'(t), 4'b0001);
  endtask

  task automatic hit(input int t);
    wr(ADDR_W'(e_off(t) & 32'hFFFF_FFFC), e_data(t) << (8 * e_off(t)[1:0]), e_be(t));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] good;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(12'h000, v); check("R1 width after reset", v, 32'h0);
    rd(12'h00C, v); check("R1 count after reset", v, 32'h0);

    // R2 R3: sweep every test number
    for (int t = 0; t < 256; t++) begin
      sel(t);
      rd(12'h000, v); check("R2 width code", v, {16'h0, e_width(t), 8'h00});
      rd(12'h004, v); check("R3 offset", v, e_off(t));
      rd(12'h008, v); check("R3 data", v, e_data(t));
    end

    for (int t = 0; t < 4; t++) begin
      logic [ADDR_W-1:0] wa;
      sel(t);
      wa = ADDR_W'(e_off(t) & 32'hFFFF_FFFC);
      good = e_data(t) << (8 * e_off(t)[1:0]);
      hit(t);
      rd(12'h00C, v); check("R4 first hit", v, 32'd1);
      wr(wa ^ 12'h004, good, e_be(t));
      wr(wa, good, e_be(t) ^ 4'b0001);
      wr(wa, good ^ (32'h1 << (8 * e_off(t)[1:0])), e_be(t));
      rd(12'h00C, v); check("R5 near misses ignored", v, 32'd1);
      wr(wa, good | ~e_bits(t), e_be(t));
      rd(12'h00C, v); check("R5 disabled lanes ignored", v, 32'd2);
      for (int k = 0; k < 8; k++) hit(t);
      rd(12'h00C, v); check("R7 saturated", v, 32'd7);
      sel(t);
      rd(12'h00C, v); check("R6 reselect clears", v, 32'd0);
    end

    sel(9);
    for (int t = 0; t < 4; t++) hit(t);
    wr(12'h300, 32'h0, 4'hF);
    rd(12'h00C, v); check("R11 invalid test counts nothing", v, 32'd0);

    sel(2); hit(2);
    wr(12'h004, 32'hFFFF_FFFF, 4'hF);
    wr(12'h008, 32'hFFFF_FFFF, 4'hF);
    wr(12'h00C, 32'hFFFF_FFFF, 4'hF);
    wr(12'h010, 32'hFFFF_FFFF, 4'hF);
    wr(12'h000, 32'h0000_0000, 4'b1110);
    rd(12'h004, v); check("R8 offset unchanged", v, 32'h300);
    rd(12'h008, v); check("R8 data unchanged", v, 32'h12345678);
    rd(12'h00C, v); check("R8 count unchanged", v, 32'd1);
    rd(12'h010, v); check("R8 name unchanged", v, 32'h5053_5542);
    rd(12'h000, v); check("R8 selection unchanged", v, 32'h0000_0400);

    rd(12'h014, v); check("R9 name bytes 20-23", v, 32'h4542_4F52);
    rd(12'h018, v); check("R9 terminator", v, 32'h0);
    rd(12'h01C, v); check("R9 unused", v, 32'h0);
    rd(12'h300, v); check("R9 target location reads 0", v, 32'h0);
    rd(12'hFFC, v); check("R9 top word reads 0", v, 32'h0);

    rd(12'h008, v);
    @(negedge clk); bus_addr = 12'h004;
    repeat (3) @(negedge clk);
    check("R10 read data held", bus_rdata, 32'h12345678);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule